// File: doc/BRIEF.md
# Eight-Level Prioritised Interrupt Controller

This block gathers eight interrupt request lines and raises one request line, `cpu_int`, toward a processor. It holds three eight-bit registers: pending requests, levels in service, and a mask. A priority resolver sits on top of them. A host programs and queries the block through an 8-bit register port made of `cs`, `wr`, `rd`, `a0` and `din`/`dout`. A separate acknowledge strobe returns a vector byte. The upper five bits of that byte come from a programmed base and the lower three bits are the level being served. Each clock cycle in which a strobe is high counts as one access.

A small sequencer controls programming. It has four states:
- `ST_UNINIT` is the state after reset.
- `ST_WANT_W2` waits for the vector-base word.
- `ST_WANT_W4` waits for an optional fourth word, whose content is discarded.
- `ST_RUN` is normal operation.

Transitions:
- A start word (write, `a0`=0, `din[4]`=1) moves any state to `ST_WANT_W2`.
- An `a0`=1 write in `ST_WANT_W2` goes to `ST_WANT_W4` when the start word had `din[0]`=1, and otherwise to `ST_RUN`.
- An `a0`=1 write in `ST_WANT_W4` goes to `ST_RUN`.
- Every other access leaves the state unchanged.

In `ST_RUN`, a write with `a0`=0 and `din[4]`=0 is a command:
- `din[3]`=1 loads the poll flag from `din[2]`.
- `din[3]`=0 selects an end-of-service or rotation operation through `din[7:5]`, with a level number in `din[2:0]`.

Priority is circular. A "lowest level" register sets the order: the level just above it is the most urgent, and the order continues upward with wrap-around. That register can be moved automatically, when service on a level ends, or by an explicit command.

Top module: `pic_core`

## Requirements
- R1: After reset `cpu_int` and `dout` are 0. No request raises `cpu_int` until the sequencer reaches `ST_RUN`.
- R2: A start word clears pending, in-service and mask bits, sets the lowest level to 7 (so IR0 is highest), and records `din[3]` (1 = level triggered) and `din[0]` (1 = fourth word expected). The next `a0`=1 write loads the vector base from `din[7:3]`. When the fourth word is expected, it is consumed and does not load the mask.
- R3: In edge mode a pending bit is set by a 0→1 change of its line. A line held high does not request again after service.
- R4: In level mode a pending bit follows its line: it sets while the line is high and clears when the line drops.
- R5: In `ST_RUN` an `a0`=1 write loads the mask and an `a0`=1 read returns it. A masked level stays pending but raises no `cpu_int`. Clearing the mask bit lets it through.
- R6: An acknowledge takes the most urgent unmasked pending level that is eligible. It sets that level's in-service bit, clears its pending bit, and returns `{base, level}` on `dout` in the following cycle.
- R7: `cpu_int` is 1 only when some unmasked pending level is strictly more urgent than every in-service level. Equal or less urgent levels wait.
- R8: Command `din[7:5]`=001 clears the most urgent in-service bit. Command 011 clears the in-service bit of level `din[2:0]`.
- R9: Command 100 turns automatic rotation on and 000 turns it off. While it is on, each 001 command also makes the cleared level the lowest. Command 101 clears and rotates once, whatever the setting.
- R10: Command 110 makes level `din[2:0]` the lowest. Command 111 clears that level's in-service bit and also makes it the lowest.
- R11: Command `din[3]`=1, `din[2]`=1 arms polling, and `cpu_int` is held at 0 while polling is armed. The next `a0`=0 read returns bit 7 = request eligible and bits 2:0 = its level. It marks that level in service and disarms polling. An `a0`=0 read without polling armed returns the pending register.
- R12: An acknowledge with no eligible level returns `{base, 3'b111}` and changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Register port select |
| wr | input | 1 | Write strobe, qualified by `cs` |
| rd | input | 1 | Read strobe, qualified by `cs` |
| a0 | input | 1 | Register address bit |
| din | input | 8 | Write data |
| inta | input | 1 | Interrupt acknowledge strobe |
| ir | input | 8 | Interrupt request lines, one per level |
| dout | output | 8 | Registered read or vector data |
| cpu_int | output | 1 | Interrupt request to the processor |

## Verification
The bench goes after the following cases, each listed with the failure it would expose:
- **Nesting.** A less urgent or equal level arrives while a level is in service. A resolver comparing with "less than or equal" would let the equal level interrupt its own handler.
- **Rotation.** Orderings are tested after automatic, one-shot and specific rotation, and again after automatic rotation is switched off. A design that kept rotating after the off command returns IR0 instead of IR6.
- **Held edge-mode line.** This catches a design that re-latches a request which was never released.
- **Level-mode line that stays high.** This catches a design that fails to re-request after end of service.
- **Poll reads.** These catch a design that leaves `cpu_int` driven, or that forgets to mark the polled level in service.
- **Acknowledge with nothing pending.** This must return level 7 and leave every register untouched.
- **Fourth word during initialisation.** This catches a design that loads it into the mask.

// File: rtl/pic_pkg.sv
package pic_pkg;

    typedef enum logic [1:0] {
        ST_UNINIT  = 2'd0,
        ST_WANT_W2 = 2'd1,
        ST_WANT_W4 = 2'd2,
        ST_RUN     = 2'd3
    } pic_state_t;

    // command field din[7:5] of an end-of-service / rotation write
    localparam logic [2:0] OP_AUTO_OFF   = 3'b000;
    localparam logic [2:0] OP_NS_EOI     = 3'b001;
    localparam logic [2:0] OP_NOP        = 3'b010;
    localparam logic [2:0] OP_SP_EOI     = 3'b011;
    localparam logic [2:0] OP_AUTO_ON    = 3'b100;
    localparam logic [2:0] OP_NS_EOI_ROT = 3'b101;
    localparam logic [2:0] OP_SET_LOW    = 3'b110;
    localparam logic [2:0] OP_SP_EOI_ROT = 3'b111;

    localparam int START_BIT = 4;
    localparam int LEVEL_BIT = 3;
    localparam int NEED4_BIT = 0;
    localparam int OCW3_BIT  = 3;
    localparam int POLL_BIT  = 2;

endpackage

// File: rtl/pic_pick.sv
module pic_pick #(
    parameter int N = 8,
    localparam int LW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    input  logic [LW-1:0] lowest,
    output logic          found,
    output logic [LW-1:0] lvl,
    output logic [LW-1:0] rank
);
    logic [LW-1:0] idx;

    // walk from least to most urgent so the most urgent hit is kept last
    always_comb begin
        found = 1'b0;
        lvl   = '0;
        rank  = '0;
        idx   = '0;
        for (int k = N - 1; k >= 0; k--) begin
            idx = lowest + LW'(1) + LW'(k);
            if (vec[idx]) begin
                found = 1'b1;
                lvl   = idx;
                rank  = LW'(k);
            end
        end
    end
endmodule

// File: rtl/pic_seq.sv
module pic_seq
    import pic_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          a0,
    input  logic [DW-1:0] din,
    output pic_state_t    state,
    output logic          level_mode,
    output logic          start_w1,
    output logic          take_base,
    output logic          take_mask,
    output logic          take_ocw2,
    output logic          take_ocw3
);
    pic_state_t state_nx;
    logic       need4;

    always_comb begin
        state_nx = state;
        if (start_w1) begin
            state_nx = ST_WANT_W2;
        end else if (wr_en && a0) begin
            unique case (state)
                ST_UNINIT:  state_nx = ST_UNINIT;
                ST_WANT_W2: state_nx = need4 ? ST_WANT_W4 : ST_RUN;
                ST_WANT_W4: state_nx = ST_RUN;
                ST_RUN:     state_nx = ST_RUN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_UNINIT;
            level_mode <= 1'b0;
            need4      <= 1'b0;
        end else begin
            state <= state_nx;
            if (start_w1) begin
                level_mode <= din[LEVEL_BIT];
                need4      <= din[NEED4_BIT];
            end
        end
    end

    always_comb begin
        start_w1  = wr_en && !a0 && din[START_BIT];
        take_base = wr_en && a0 && (state == ST_WANT_W2);
        take_mask = wr_en && a0 && (state == ST_RUN);
        take_ocw2 = wr_en && !a0 && !din[START_BIT] && !din[OCW3_BIT] && (state == ST_RUN);
        take_ocw3 = wr_en && !a0 && !din[START_BIT] && din[OCW3_BIT] && (state == ST_RUN);
    end

    AST_START_GOES_W2: assert property (@(posedge clk) disable iff (!rst_n)
        start_w1 |=> state == ST_WANT_W2); // R2
endmodule

// File: rtl/pic_core.sv
module pic_core
    import pic_pkg::*;
#(
    parameter int N_IRQ = 8,
    parameter int DW    = 8,
    localparam int LW = $clog2(N_IRQ),
    localparam int BW = DW - LW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs,
    input  logic             wr,
    input  logic             rd,
    input  logic             a0,
    input  logic [DW-1:0]    din,
    input  logic             inta,
    input  logic [N_IRQ-1:0] ir,
    output logic [DW-1:0]    dout,
    output logic             cpu_int
);
    pic_state_t       st;
    logic             level_mode, start_w1, take_base, take_mask, take_ocw2, take_ocw3;
    logic [N_IRQ-1:0] irr, isr, imr, ir_prev, pend, irr_nx, serve_mask, eoi_clr;
    logic [BW-1:0]    base;
    logic [LW-1:0]    low_lvl, rot_to, p_lvl, p_rank, s_lvl, s_rank, sel;
    logic             auto_rot, auto_nx, poll_arm, rot_en;
    logic             p_found, s_found, eligible, wr_en, rd_en, poll_rd, serve;
    logic [2:0]       op;

    assign wr_en = cs && wr;
    assign rd_en = cs && rd;
    assign op    = din[DW-1 -: 3];
    assign sel   = din[LW-1:0];
    assign pend  = irr & ~imr;

    pic_seq #(.DW(DW)) u_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .a0(a0), .din(din),
        .state(st), .level_mode(level_mode), .start_w1(start_w1),
        .take_base(take_base), .take_mask(take_mask),
        .take_ocw2(take_ocw2), .take_ocw3(take_ocw3)
    );

    pic_pick #(.N(N_IRQ)) u_pend (
        .vec(pend), .lowest(low_lvl), .found(p_found), .lvl(p_lvl), .rank(p_rank)
    );

    pic_pick #(.N(N_IRQ)) u_serv (
        .vec(isr), .lowest(low_lvl), .found(s_found), .lvl(s_lvl), .rank(s_rank)
    );

    assign eligible   = p_found && (!s_found || (p_rank < s_rank));
    assign cpu_int    = (st == ST_RUN) && !poll_arm && eligible;
    assign poll_rd    = rd_en && !a0 && poll_arm && !inta;
    assign serve      = (inta || poll_rd) && eligible;
    assign serve_mask = serve ? (N_IRQ'(1) << p_lvl) : '0;

    always_comb begin
        irr_nx = level_mode ? ir : (irr | (ir & ~ir_prev));
        irr_nx = irr_nx & ~serve_mask;
    end

    always_comb begin
        eoi_clr = '0;
        rot_en  = 1'b0;
        rot_to  = low_lvl;
        auto_nx = auto_rot;
        if (take_ocw2) begin
            unique case (op)
                OP_AUTO_OFF: auto_nx = 1'b0;
                OP_AUTO_ON:  auto_nx = 1'b1;
                OP_NS_EOI, OP_NS_EOI_ROT: begin
                    if (s_found) begin
                        eoi_clr = N_IRQ'(1) << s_lvl;
                        rot_en  = (op == OP_NS_EOI_ROT) || auto_rot;
                        rot_to  = s_lvl;
                    end
                end
                OP_SP_EOI: eoi_clr = N_IRQ'(1) << sel;
                OP_SP_EOI_ROT: begin
                    eoi_clr = N_IRQ'(1) << sel;
                    rot_en  = 1'b1;
                    rot_to  = sel;
                end
                OP_SET_LOW: begin
                    rot_en = 1'b1;
                    rot_to = sel;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irr      <= '0;
            isr      <= '0;
            imr      <= '0;
            ir_prev  <= '0;
            base     <= '0;
            low_lvl  <= LW'(N_IRQ - 1);
            auto_rot <= 1'b0;
            poll_arm <= 1'b0;
        end else begin
            ir_prev <= ir;
            if (take_base) base <= din[DW-1 -: BW];
            if (start_w1) begin
                irr      <= '0;
                isr      <= '0;
                imr      <= '0;
                low_lvl  <= LW'(N_IRQ - 1);
                auto_rot <= 1'b0;
                poll_arm <= 1'b0;
            end else begin
                irr      <= irr_nx;
                isr      <= (isr & ~eoi_clr) | serve_mask;
                auto_rot <= auto_nx;
                if (take_mask) imr <= din[N_IRQ-1:0];
                if (rot_en) low_lvl <= rot_to;
                if (take_ocw3) poll_arm <= din[POLL_BIT];
                else if (poll_rd) poll_arm <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= '0;
        end else if (inta) begin
            dout <= {base, eligible ? p_lvl : {LW{1'b1}}};
        end else if (rd_en) begin
            if (a0)            dout <= DW'(imr);
            else if (poll_arm) dout <= {eligible, (DW-1-LW)'(0), eligible ? p_lvl : LW'(0)};
            else               dout <= DW'(irr);
        end
    end

    AST_ACK_ADDS_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && cpu_int && !wr_en) |=> ($countones(isr) == $countones($past(isr)) + 1)); // R6
    AST_EOI_DROPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (take_ocw2 && op == OP_NS_EOI && isr != '0 && !inta && !poll_rd)
        |=> ($countones(isr) + 1 == $countones($past(isr)))); // R8
    AST_MASK_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_int |-> ((irr & ~imr) != '0)); // R5
    AST_POLL_HUSHES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !a0 && !din[START_BIT] && din[OCW3_BIT] && din[POLL_BIT] && st == ST_RUN)
        |=> !cpu_int); // R11
    AST_DOUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en && !inta) |=> $stable(dout)); // R6
endmodule

// File: tb/pic_core_test.sv
module pic_core_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs = 0, wr = 0, rd = 0, a0 = 0, inta = 0;
    logic [7:0] din = 0, ir = 0;
    logic [7:0] dout;
    logic       cpu_int;
    int         total = 0, bad = 0, cyc = 0;

    always #4 clk = ~clk;

    pic_core uut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .rd(rd), .a0(a0), .din(din),
        .inta(inta), .ir(ir), .dout(dout), .cpu_int(cpu_int)
    );

    // behavioural reference
    int         m_st, m_low, m_base;
    bit         m_auto, m_poll, m_level, m_need4, m_int;
    logic [7:0] m_irr, m_isr, m_imr, m_prev, m_dout;

    task automatic best(input logic [7:0] v, output bit f, output int l, output int r);
        f = 0; l = 0; r = 99;
        for (int i = 0; i < 8; i++) begin
            int rk = (i - m_low + 15) % 8;
            if (v[i] && rk < r) begin f = 1; l = i; r = rk; end
        end
    endtask

    always @(posedge clk) begin : model
        bit pf, sf, elig, wen, ren, prd;
        int pl, pr, sl, sr;
        logic [7:0] nirr;
        if (!rst_n) begin
            m_st = 0; m_irr = 0; m_isr = 0; m_imr = 0; m_base = 0; m_low = 7;
            m_auto = 0; m_poll = 0; m_level = 0; m_need4 = 0; m_prev = 0; m_dout = 0;
        end else begin
            best(m_irr & ~m_imr, pf, pl, pr);
            best(m_isr, sf, sl, sr);
            elig = pf && (!sf || pr < sr);
            wen = cs && wr; ren = cs && rd;
            prd = ren && !a0 && m_poll && !inta;
            if (inta) m_dout = 8'(m_base * 8 + (elig ? pl : 7));
            else if (ren) m_dout = a0 ? m_imr : (m_poll ? (elig ? 8'(128 + pl) : 8'h00) : m_irr);
            for (int i = 0; i < 8; i++)
                nirr[i] = m_level ? ir[i] : (m_irr[i] | (ir[i] & !m_prev[i]));
            if ((inta || prd) && elig) nirr[pl] = 0;
            if (wen && !a0 && din[4]) begin
                m_st = 1; m_level = din[3]; m_need4 = din[0];
                m_irr = 0; m_isr = 0; m_imr = 0; m_low = 7; m_auto = 0; m_poll = 0;
            end else begin
                if (wen && a0) begin
                    if (m_st == 1) begin m_base = din >> 3; m_st = m_need4 ? 2 : 3; end
                    else if (m_st == 2) m_st = 3;
                    else if (m_st == 3) m_imr = din;
                end else if (wen && !a0 && m_st == 3) begin
                    if (din[3]) m_poll = din[2];
                    else case (din[7:5])
                        3'd0: m_auto = 0;
                        3'd4: m_auto = 1;
                        3'd1, 3'd5: if (sf) begin
                            m_isr[sl] = 0;
                            if (din[7:5] == 3'd5 || m_auto) m_low = sl;
                        end
                        3'd3: m_isr[din[2:0]] = 0;
                        3'd7: begin m_isr[din[2:0]] = 0; m_low = din[2:0]; end
                        3'd6: m_low = din[2:0];
                        default: ;
                    endcase
                end
                if (prd) m_poll = 0;
                if ((inta || prd) && elig) m_isr[pl] = 1;
                m_irr = nirr;
            end
            m_prev = ir;
        end
        best(m_irr & ~m_imr, pf, pl, pr);
        best(m_isr, sf, sl, sr);
        m_int = (m_st == 3) && !m_poll && pf && (!sf || pr < sr);
    end

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) if (rst_n) begin
        check("R7 cpu_int vs model", cpu_int, m_int);
        check("R6 dout vs model", dout, m_dout);
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            bad++;
            $display("FAIL R1 watchdog actual=%0d expected<100000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic wreg(input bit a, input logic [7:0] d);
        @(negedge clk); cs = 1; wr = 1; a0 = a; din = d;
        @(negedge clk); cs = 0; wr = 0;
    endtask
    task automatic rreg(input bit a);
        @(negedge clk); cs = 1; rd = 1; a0 = a;
        @(negedge clk); cs = 0; rd = 0;
    endtask
    task automatic ack();
        @(negedge clk); inta = 1;
        @(negedge clk); inta = 0;
    endtask
    task automatic setir(input logic [7:0] v);
        @(negedge clk); ir = v;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 int after reset", cpu_int, 0);
        check("R1 dout after reset", dout, 0);
        setir(8'h04); setir(8'h04);
        check("R1 no int before init", cpu_int, 0);
        setir(8'h00);

        // R2 init with fourth word
        wreg(0, 8'h11); wreg(1, 8'h48); wreg(1, 8'h01);
        rreg(1); check("R2 fourth word not in mask", dout, 8'h00);
        wreg(1, 8'hA5); rreg(1); check("R5 mask readback", dout, 8'hA5);
        wreg(1, 8'h00);

        // R3 edge trigger
        setir(8'h20); check("R3 edge raises int", cpu_int, 1);
        ack(); check("R6 vector level5", dout, 8'h4D);
        check("R7 served blocks", cpu_int, 0);
        wreg(0, 8'h20); check("R3 held line no re-request", cpu_int, 0);
        setir(8'h00);

        // R7 nesting, R8 EOI
        setir(8'h10); ack(); check("R6 vector level4", dout, 8'h4C);
        setir(8'h50); check("R7 lower blocked", cpu_int, 0);
        setir(8'h40); setir(8'h50); check("R7 equal blocked", cpu_int, 0);
        setir(8'h52); check("R7 higher passes", cpu_int, 1);
        ack(); check("R6 vector level1", dout, 8'h49);
        wreg(0, 8'h20); check("R8 ns eoi clears top only", cpu_int, 0);
        rreg(0); check("R11 plain read gives pending", dout, 8'h50);
        wreg(0, 8'h64); check("R8 specific eoi", cpu_int, 1);
        ack(); check("R8 level4 served", dout, 8'h4C);
        wreg(0, 8'h20); ack(); check("R8 then level6", dout, 8'h4E);
        wreg(0, 8'h20); check("R8 all clear", cpu_int, 0);
        setir(8'h00);

        // R5 masking
        wreg(1, 8'h08); setir(8'h08); check("R5 masked no int", cpu_int, 0);
        rreg(0); check("R5 masked still pending", dout, 8'h08);
        wreg(1, 8'h00); check("R5 unmask raises", cpu_int, 1);
        ack(); check("R5 vector level3", dout, 8'h4B);
        wreg(0, 8'h20); setir(8'h00);

        // R12 spurious
        ack(); check("R12 spurious vector", dout, 8'h4F);
        rreg(0); check("R12 pending untouched", dout, 8'h00);

        // R9 automatic rotation
        wreg(0, 8'h80); setir(8'h09); ack(); check("R9 first IR0", dout, 8'h48);
        wreg(0, 8'h20); ack(); check("R9 then IR3", dout, 8'h4B);
        wreg(0, 8'h20); setir(8'h00); setir(8'h21);
        ack(); check("R9 rotated order picks IR5", dout, 8'h4D);
        wreg(0, 8'h20); wreg(0, 8'h00); setir(8'h00); setir(8'h80);
        ack(); check("R9 IR7 before IR0", dout, 8'h4F);
        wreg(0, 8'h20); setir(8'h00); setir(8'h40);
        ack(); check("R9 rotation off keeps order", dout, 8'h4E);
        wreg(0, 8'h20); ack(); check("R9 IR0 last", dout, 8'h48);
        wreg(0, 8'h20); setir(8'h00);

        // R10 specific rotation
        wreg(0, 8'hC2); setir(8'h05); ack(); check("R10 IR0 before IR2", dout, 8'h48);
        wreg(0, 8'h20); ack(); check("R10 IR2", dout, 8'h4A);
        wreg(0, 8'hE2); check("R10 spec eoi rot", cpu_int, 0);
        setir(8'h00); setir(8'h81); ack(); check("R10 IR7 before IR0", dout, 8'h4F);
        wreg(0, 8'hE7); ack(); check("R10 rotate to 7", dout, 8'h48);
        wreg(0, 8'hA0); setir(8'h00); setir(8'h82);
        ack(); check("R9 one-shot rotate IR1", dout, 8'h49);
        wreg(0, 8'h20); ack(); check("R10 IR7 after", dout, 8'h4F);
        wreg(0, 8'h20); setir(8'h00);

        // R11 poll
        wreg(0, 8'h0C); setir(8'h10); check("R11 int quiet in poll", cpu_int, 0);
        rreg(0); check("R11 poll word", dout, 8'h84);
        setir(8'h50); check("R11 polled level in service", cpu_int, 0);
        wreg(0, 8'h20); check("R11 after eoi", cpu_int, 1);
        ack(); check("R11 IR6 vector", dout, 8'h4E);
        wreg(0, 8'h20); setir(8'h00);
        wreg(0, 8'h0C); rreg(0); check("R11 empty poll", dout, 8'h00);

        // R4 level mode, R2 reinit
        wreg(0, 8'h18); wreg(1, 8'h20); rreg(1); check("R2 reinit clears mask", dout, 8'h00);
        wreg(1, 8'h00);
        setir(8'h08); check("R4 level raises", cpu_int, 1);
        setir(8'h00); check("R4 level drops", cpu_int, 0);
        rreg(0); check("R4 pending follows line", dout, 8'h00);
        setir(8'h08); ack(); check("R4 vector", dout, 8'h23);
        wreg(0, 8'h20); check("R4 line high re-requests", cpu_int, 1);
        ack(); setir(8'h00); wreg(0, 8'h20); check("R4 idle", cpu_int, 0);
        setir(8'h81); ack(); check("R2 order reset IR0", dout, 8'h20);
        setir(8'h00); wreg(0, 8'h20);
        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule